// File: doc/BRIEF.md
# Coalescing Interrupt Source State Engine

This block holds a two-bit pending/queued state (written here as P and Q) for each of a set of interrupt sources. It changes that state on three kinds of event:

- edges on wired trigger inputs;
- trigger stores arriving over a 64-bit memory-mapped bus;
- end-of-interrupt and direct state-write commands on the same bus.

A source that is triggered while already pending does not produce a second notification. The Q bit records the extra event instead, and a later end-of-interrupt replays it. Every transition that calls for delivery pushes the source number into a small notification FIFO. That FIFO drains one entry per cycle as a single-cycle notify pulse. A routing stage downstream consumes the pulse.

Each source owns an address window of 2^SHIFT bytes. The source number is the address shifted right by SHIFT, and the command is decoded from the low twelve address bits. Loads return the previous state atomically, so software reads the old P/Q value and changes it in one access. When SHIFT is 13 or 17, the window splits in two. Address bit SHIFT-1 set to 0 selects a trigger-only page, and set to 1 selects the management page. With SHIFT 12 or 16, a single page serves both roles under the management rules.

Top module: `irq_pq_engine`

## Requirements
- R1: After reset every source holds P/Q = 01 (off), and notify_valid, rsp_valid and bus_err are low.
- R2: A trigger moves 00 to 10 and raises a notification. It moves 10 or 11 to 11 without one, and leaves 01 unchanged without one. P is bit 1 and Q is bit 0.
- R3: A management-page load with offset 0x000-0x7FF performs an end-of-interrupt and returns 1 if it notified, else 0. The end-of-interrupt moves 00 and 10 to 00 silently, moves 11 to 10 with a notification, and leaves 01 unchanged.
- R4: A management-page load with offset 0x800-0xBFF returns the current P/Q. A load with offset 0xC00-0xFFF writes P/Q = offset bits [9:8] and returns the previous P/Q. Load data is the doubleword value with the result in bits [1:0] and zeros above, so on the big-endian bus it sits in the highest-addressed byte.
- R5: A management-page store with offset 0x000-0x3FF is a trigger. A store with offset 0xC00-0xFFF writes P/Q = offset bits [9:8].
- R6: A management-page store with offset 0x400-0x7FF performs an end-of-interrupt when parameter STORE_EOI is 1. When STORE_EOI is 0, the store changes nothing and raises bus_err.
- R7: In the two-page layout (SHIFT 13 or 17), any store to the trigger page (address bit SHIFT-1 = 0) is a trigger whatever its offset. A load from the trigger page returns all ones, raises bus_err and changes no state.
- R8: A store with offset 0x800-0xBFF, an access with bus_size other than 8, or an access whose source number is NUM_SRC or above raises bus_err for one cycle and changes no state. A load in any of these cases returns all ones.
- R9: A 0-to-1 edge on irq_in[i] applies one trigger to source i. Holding the input high or dropping it applies nothing.
- R10: When a bus command and a wired trigger reach the same source in the same cycle, the bus command is applied first and the trigger second.
- R11: At most one notification leaves per cycle and none is lost. A notification caused by a bus command leaves before one caused by a wired trigger in the same cycle, and among waiting wired edges the lowest source number goes first.
- R12: rsp_valid, rsp_data and bus_err appear in the cycle after the bus command is sampled. With an empty FIFO, the notification appears in that same following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_SRC | Wired trigger inputs, one per source, edge sensitive |
| bus_valid | input | 1 | Bus command present this cycle |
| bus_write | input | 1 | 1 = store, 0 = load |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_size | input | 4 | Access size in bytes; only 8 is accepted |
| rsp_valid | output | 1 | Load result valid |
| rsp_data | output | 64 | Load result doubleword |
| bus_err | output | 1 | One-cycle flag for a rejected access |
| notify_valid | output | 1 | Notification pulse |
| notify_src | output | SRC_W | Source number carried by the notification |

## Verification
A table walks one management-page source through every P/Q value, with each command class applied in each state. A wrong transition therefore shows up either in the returned old value or in the presence or absence of a notify pulse. The trigger page, an illegal offset, a short access and an out-of-range source number are each aimed at a source with known state. A read-back then tells a dropped access from one that acted on the wrong page or on an aliased source. Two same-cycle collisions are chosen so that the two possible application orders leave different end states. A burst of eight simultaneous wired edges plus a bus trigger exposes lost, duplicated or misordered notifications. A second instance in the one-page layout, with store end-of-interrupt disabled, separates the parameter variants.

// File: rtl/irq_pq_pkg.sv
package irq_pq_pkg;

    // P/Q encodings: P is bit 1, Q is bit 0
    localparam logic [1:0] PQ_IDLE       = 2'b00;
    localparam logic [1:0] PQ_OFF        = 2'b01;
    localparam logic [1:0] PQ_PEND       = 2'b10;
    localparam logic [1:0] PQ_PEND_AGAIN = 2'b11;

    localparam int unsigned DWORD_BYTES = 8;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_TRIG,
        OP_EOI,
        OP_GET,
        OP_SET,
        OP_BAD
    } op_e;

    typedef struct packed {
        logic       fire;
        logic [1:0] nxt;
    } pq_step_t;

    // Trigger: idle arms and notifies, pending coalesces into Q, off stays off
    function automatic pq_step_t pq_on_trigger(input logic [1:0] cur);
        pq_step_t s;
        s.fire = 1'b0;
        s.nxt  = cur;
        unique case (cur)
            PQ_IDLE: begin
                s.nxt  = PQ_PEND;
                s.fire = 1'b1;
            end
            PQ_PEND, PQ_PEND_AGAIN: s.nxt = PQ_PEND_AGAIN;
            default: s.nxt = PQ_OFF;
        endcase
        return s;
    endfunction

    // End of interrupt: a recorded Q replays as a fresh notification
    function automatic pq_step_t pq_on_eoi(input logic [1:0] cur);
        pq_step_t s;
        s.fire = 1'b0;
        s.nxt  = cur;
        unique case (cur)
            PQ_IDLE, PQ_PEND: s.nxt = PQ_IDLE;
            PQ_PEND_AGAIN: begin
                s.nxt  = PQ_PEND;
                s.fire = 1'b1;
            end
            default: s.nxt = PQ_OFF;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/irq_pq_decode.sv
module irq_pq_decode
    import irq_pq_pkg::*;
#(
    parameter int NUM_SRC   = 8,
    parameter int SHIFT     = 17,
    parameter int ADDR_W    = 24,
    parameter bit STORE_EOI = 1'b1,
    parameter int SRC_W     = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic              valid,
    input  logic              write,
    input  logic [ADDR_W-1:0] addr,
    input  logic [3:0]        size,
    output op_e               op,
    output logic [SRC_W-1:0]  src,
    output logic [1:0]        set_val
);

    localparam int FIELD_W = ADDR_W - SHIFT;
    localparam bit SPLIT   = (SHIFT == 13) || (SHIFT == 17);

    logic [FIELD_W-1:0] field;
    logic [11:0]        off;
    logic               src_ok;
    logic               trig_page;

    assign field   = addr[ADDR_W-1:SHIFT];
    assign off     = addr[11:0];
    assign src_ok  = int'(field) < NUM_SRC;
    assign src     = field[SRC_W-1:0];
    assign set_val = off[9:8];

    generate
        if (SPLIT) begin : g_split
            assign trig_page = ~addr[SHIFT-1];
        end else begin : g_single
            assign trig_page = 1'b0;
        end
    endgenerate

    always_comb begin
        op = OP_NONE;
        if (valid) begin
            if (size != 4'(DWORD_BYTES) || !src_ok) begin
                op = OP_BAD;
            end else if (trig_page) begin
                op = write ? OP_TRIG : OP_BAD;
            end else if (write) begin
                unique case (off[11:10])
                    2'b00:   op = OP_TRIG;
                    2'b01:   op = STORE_EOI ? OP_EOI : OP_BAD;
                    2'b10:   op = OP_BAD;
                    default: op = OP_SET;
                endcase
            end else begin
                unique case (off[11:10])
                    2'b00, 2'b01: op = OP_EOI;
                    2'b10:        op = OP_GET;
                    default:      op = OP_SET;
                endcase
            end
        end
    end

endmodule

// File: rtl/irq_pq_wired.sv
module irq_pq_wired #(
    parameter int NUM_SRC = 8,
    parameter int SRC_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_in,
    input  logic               grant_en,
    output logic               req_valid,
    output logic [SRC_W-1:0]   req_src
);

    typedef struct packed {
        logic [NUM_SRC-1:0] prev;
        logic [NUM_SRC-1:0] pend;
    } wired_regs_t;

    wired_regs_t r_q, r_d;
    logic [NUM_SRC-1:0] cand;
    logic [NUM_SRC-1:0] taken;

    always_comb begin
        r_d       = r_q;
        cand      = r_q.pend | (irq_in & ~r_q.prev);
        req_valid = |cand;
        req_src   = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (cand[i]) begin
                req_src = SRC_W'(i);
            end
        end
        taken = '0;
        if (req_valid && grant_en) begin
            taken[req_src] = 1'b1;
        end
        r_d.pend = cand & ~taken;
        r_d.prev = irq_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

endmodule

// File: rtl/irq_pq_notify_fifo.sv
module irq_pq_notify_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 3,
    parameter int PW    = $clog2(DEPTH),
    parameter int LVL_W = $clog2(DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push0,
    input  logic [W-1:0]     data0,
    input  logic             push1,
    input  logic [W-1:0]     data1,
    output logic             out_valid,
    output logic [W-1:0]     out_data,
    output logic [LVL_W-1:0] level
);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           wr;
        logic [PW-1:0]           rd;
        logic [LVL_W-1:0]        cnt;
    } fifo_regs_t;

    fifo_regs_t r_q, r_d;
    logic [PW-1:0] slot;
    logic          pop;

    always_comb begin
        r_d  = r_q;
        pop  = (r_q.cnt != '0);
        slot = r_q.wr;
        // first push port always lands ahead of the second
        if (push0) begin
            r_d.mem[slot] = data0;
            slot          = slot + 1'b1;
        end
        if (push1) begin
            r_d.mem[slot] = data1;
            slot          = slot + 1'b1;
        end
        r_d.wr = slot;
        if (pop) begin
            r_d.rd = r_q.rd + 1'b1;
        end
        r_d.cnt = r_q.cnt + LVL_W'(push0) + LVL_W'(push1) - LVL_W'(pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign out_valid = (r_q.cnt != '0);
    assign out_data  = r_q.mem[r_q.rd];
    assign level     = r_q.cnt;

endmodule

// File: rtl/irq_pq_engine.sv
module irq_pq_engine
    import irq_pq_pkg::*;
#(
    parameter int NUM_SRC    = 8,
    parameter int SHIFT      = 17,
    parameter int ADDR_W     = 24,
    parameter bit STORE_EOI  = 1'b1,
    parameter int FIFO_DEPTH = 4,
    parameter int SRC_W      = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_in,
    input  logic               bus_valid,
    input  logic               bus_write,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [3:0]         bus_size,
    output logic               rsp_valid,
    output logic [63:0]        rsp_data,
    output logic               bus_err,
    output logic               notify_valid,
    output logic [SRC_W-1:0]   notify_src
);

    localparam int LVL_W = $clog2(FIFO_DEPTH) + 1;

    typedef struct packed {
        logic [NUM_SRC-1:0][1:0] pq;
        logic                    rsp_valid;
        logic [63:0]             rsp_data;
        logic                    err;
    } eng_regs_t;

    eng_regs_t r_q, r_d;

    op_e              dec_op;
    logic [SRC_W-1:0] dec_src;
    logic [1:0]       dec_set;
    logic             set_cmd;
    logic             req_valid;
    logic [SRC_W-1:0] req_src;
    logic             grant_en;
    logic             wire_go;
    logic [LVL_W-1:0] fifo_level;
    logic [1:0]       cur;
    pq_step_t         bus_step;
    pq_step_t         wire_step;
    logic             bus_fire;
    logic             wire_fire;

    irq_pq_decode #(
        .NUM_SRC   (NUM_SRC),
        .SHIFT     (SHIFT),
        .ADDR_W    (ADDR_W),
        .STORE_EOI (STORE_EOI),
        .SRC_W     (SRC_W)
    ) u_decode (
        .valid   (bus_valid),
        .write   (bus_write),
        .addr    (bus_addr),
        .size    (bus_size),
        .op      (dec_op),
        .src     (dec_src),
        .set_val (dec_set)
    );

    irq_pq_wired #(
        .NUM_SRC (NUM_SRC),
        .SRC_W   (SRC_W)
    ) u_wired (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_in    (irq_in),
        .grant_en  (grant_en),
        .req_valid (req_valid),
        .req_src   (req_src)
    );

    irq_pq_notify_fifo #(
        .DEPTH (FIFO_DEPTH),
        .W     (SRC_W)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push0     (bus_fire),
        .data0     (dec_src),
        .push1     (wire_fire),
        .data1     (req_src),
        .out_valid (notify_valid),
        .out_data  (notify_src),
        .level     (fifo_level)
    );

    assign set_cmd = (dec_op == OP_SET);
    assign wire_go = req_valid && grant_en;

    always_comb begin
        r_d           = r_q;
        r_d.rsp_valid = bus_valid && !bus_write && (dec_op != OP_NONE);
        r_d.rsp_data  = '0;
        r_d.err       = 1'b0;
        cur           = r_q.pq[dec_src];
        bus_step      = '0;
        wire_step     = '0;
        bus_fire      = 1'b0;
        wire_fire     = 1'b0;

        // bus command goes first
        unique case (dec_op)
            OP_TRIG: begin
                bus_step            = pq_on_trigger(cur);
                r_d.pq[dec_src]     = bus_step.nxt;
                bus_fire            = bus_step.fire;
            end
            OP_EOI: begin
                bus_step            = pq_on_eoi(cur);
                r_d.pq[dec_src]     = bus_step.nxt;
                bus_fire            = bus_step.fire;
                r_d.rsp_data        = {63'd0, bus_step.fire};
            end
            OP_GET: begin
                r_d.rsp_data        = {62'd0, cur};
            end
            OP_SET: begin
                r_d.pq[dec_src]     = dec_set;
                r_d.rsp_data        = {62'd0, cur};
            end
            OP_BAD: begin
                r_d.err             = 1'b1;
                r_d.rsp_data        = '1;
            end
            default: ;
        endcase

        // a wired trigger is taken only if the FIFO keeps room for both pushes
        grant_en = (int'(fifo_level) - int'(notify_valid) + int'(bus_fire) + 1)
                   <= FIFO_DEPTH;

        // wired trigger goes second, on the already-updated state
        if (req_valid && grant_en) begin
            wire_step       = pq_on_trigger(r_d.pq[req_src]);
            r_d.pq[req_src] = wire_step.nxt;
            wire_fire       = wire_step.fire;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.pq        <= {NUM_SRC{PQ_OFF}};
            r_q.rsp_valid <= 1'b0;
            r_q.rsp_data  <= '0;
            r_q.err       <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign rsp_valid = r_q.rsp_valid;
    assign rsp_data  = r_q.rsp_data;
    assign bus_err   = r_q.err;

endmodule

// File: rtl/irq_pq_checks.sv
module irq_pq_checks #(
    parameter int NUM_SRC    = 8,
    parameter int SRC_W      = 3,
    parameter int FIFO_DEPTH = 4,
    parameter int LVL_W      = 3
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    bus_valid,
    input logic                    bus_write,
    input logic                    rsp_valid,
    input logic [63:0]             rsp_data,
    input logic                    bus_err,
    input logic                    notify_valid,
    input logic [SRC_W-1:0]        notify_src,
    input logic [NUM_SRC-1:0][1:0] pq,
    input logic                    set_go,
    input logic [SRC_W-1:0]        bus_src,
    input logic                    wired_go,
    input logic [LVL_W-1:0]        fifo_level
);

    assert_rsp_after_load_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(bus_valid && !bus_write));

    assert_err_load_ones_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && bus_err) |-> (rsp_data == '1));

    assert_err_keeps_state_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_err && !$past(wired_go)) |-> $stable(pq));

    assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
        int'(fifo_level) <= FIFO_DEPTH);

    assert_notify_in_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
        notify_valid |-> (int'(notify_src) < NUM_SRC));

    generate
        for (genvar i = 0; i < NUM_SRC; i++) begin : g_off
            assert_off_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(pq[i] == 2'b01) && !$past(set_go && (int'(bus_src) == i)))
                |-> (pq[i] == 2'b01));
        end
    endgenerate

endmodule

bind irq_pq_engine irq_pq_checks #(
    .NUM_SRC    (NUM_SRC),
    .SRC_W      (SRC_W),
    .FIFO_DEPTH (FIFO_DEPTH),
    .LVL_W      (LVL_W)
) u_checks (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_valid    (bus_valid),
    .bus_write    (bus_write),
    .rsp_valid    (rsp_valid),
    .rsp_data     (rsp_data),
    .bus_err      (bus_err),
    .notify_valid (notify_valid),
    .notify_src   (notify_src),
    .pq           (r_q.pq),
    .set_go       (set_cmd),
    .bus_src      (dec_src),
    .wired_go     (wire_go),
    .fifo_level   (fifo_level)
);

// File: tb/test_irq_pq_engine.sv
module test_irq_pq_engine;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    // instance A: two-page layout, store EOI enabled
    logic [7:0]  irq_a = '0;
    logic        a_valid = 1'b0, a_write = 1'b0;
    logic [23:0] a_addr = '0;
    logic [3:0]  a_size = 4'd8;
    logic        a_rv, a_err, a_nv;
    logic [63:0] a_rd;
    logic [2:0]  a_ns;

    // instance B: one-page layout, store EOI disabled
    logic [3:0]  irq_b = '0;
    logic        b_valid = 1'b0, b_write = 1'b0;
    logic [15:0] b_addr = '0;
    logic [3:0]  b_size = 4'd8;
    logic        b_rv, b_err, b_nv;
    logic [63:0] b_rd;
    logic [1:0]  b_ns;

    irq_pq_engine #(.NUM_SRC(8), .SHIFT(17), .ADDR_W(24), .STORE_EOI(1'b1), .FIFO_DEPTH(4))
    i_irq_pq_engine (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_a),
        .bus_valid(a_valid), .bus_write(a_write), .bus_addr(a_addr), .bus_size(a_size),
        .rsp_valid(a_rv), .rsp_data(a_rd), .bus_err(a_err),
        .notify_valid(a_nv), .notify_src(a_ns)
    );

    irq_pq_engine #(.NUM_SRC(4), .SHIFT(12), .ADDR_W(16), .STORE_EOI(1'b0), .FIFO_DEPTH(4))
    i_irq_pq_engine_b (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_b),
        .bus_valid(b_valid), .bus_write(b_write), .bus_addr(b_addr), .bus_size(b_size),
        .rsp_valid(b_rv), .rsp_data(b_rd), .bus_err(b_err),
        .notify_valid(b_nv), .notify_src(b_ns)
    );

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    int seen[$];

    always @(negedge clk) begin
        if (rst_n && a_nv) seen.push_back(int'(a_ns));
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [23:0] adr_a(input int src, input bit mgmt, input logic [11:0] off);
        return 24'(src << 17) | 24'({mgmt, 16'h0}) | 24'(off);
    endfunction

    // caller sits just after a negedge; outputs sampled one cycle later
    task automatic bus_a(input bit wr, input logic [23:0] addr, input logic [3:0] sz);
        a_valid = 1'b1; a_write = wr; a_addr = addr; a_size = sz;
        @(negedge clk);
        a_valid = 1'b0; a_size = 4'd8;
    endtask

    task automatic bus_b(input bit wr, input logic [15:0] addr);
        b_valid = 1'b1; b_write = wr; b_addr = addr;
        @(negedge clk);
        b_valid = 1'b0;
    endtask

    task automatic get_a(input int src, input logic [1:0] exp, input string tag);
        bus_a(1'b0, adr_a(src, 1'b1, 12'h800), 4'd8);
        chk(a_rv && a_rd == {62'd0, exp}, tag, a_rd, {62'd0, exp});
    endtask

    typedef struct packed {
        logic        wr;
        logic [11:0] off;
        logic        rv;
        logic [1:0]  rd;
        logic        nv;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 12'h800, 1'b1, 2'b01, 1'b0, 4'd4},  // R4 get off
        '{1'b1, 12'h000, 1'b0, 2'b00, 1'b0, 4'd2},  // R2 trigger while off
        '{1'b0, 12'hC00, 1'b1, 2'b01, 1'b0, 4'd4},  // R4 set 00 returns old
        '{1'b1, 12'h000, 1'b0, 2'b00, 1'b1, 4'd2},  // R2 00->10 notify
        '{1'b1, 12'h000, 1'b0, 2'b00, 1'b0, 4'd2},  // R2 10->11
        '{1'b1, 12'h3F8, 1'b0, 2'b00, 1'b0, 4'd2},  // R2 11->11
        '{1'b0, 12'h800, 1'b1, 2'b11, 1'b0, 4'd4},  // R4 get 11
        '{1'b0, 12'h000, 1'b1, 2'b01, 1'b1, 4'd3},  // R3 eoi 11->10 notify
        '{1'b0, 12'h400, 1'b1, 2'b00, 1'b0, 4'd3},  // R3 eoi 10->00
        '{1'b0, 12'h7F8, 1'b1, 2'b00, 1'b0, 4'd3},  // R3 eoi 00->00
        '{1'b1, 12'hE00, 1'b0, 2'b00, 1'b0, 4'd5},  // R5 store set 10
        '{1'b1, 12'h400, 1'b0, 2'b00, 1'b0, 4'd6},  // R6 store eoi 10->00
        '{1'b1, 12'hF00, 1'b0, 2'b00, 1'b0, 4'd5},  // R5 store set 11
        '{1'b1, 12'h480, 1'b0, 2'b00, 1'b1, 4'd6},  // R6 store eoi 11->10 notify
        '{1'b0, 12'hD00, 1'b1, 2'b10, 1'b0, 4'd4},  // R4 set 01 returns 10
        '{1'b0, 12'h000, 1'b1, 2'b00, 1'b0, 4'd3},  // R3 eoi while off
        '{1'b0, 12'hBF8, 1'b1, 2'b01, 1'b0, 4'd4}   // R4 get off
    };

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(!a_nv && !a_rv && !a_err, "R1 idle outputs", {61'd0, a_nv, a_rv, a_err}, 64'd0);
        for (int s = 0; s < 8; s++) get_a(s, 2'b01, "R1 source off after reset");

        // table walk on source 2, management page; timing per R12
        for (int v = 0; v < NV; v++) begin
            vec_t e;
            string tag;
            e = VECS[v];
            tag = $sformatf("R%0d vector %0d", e.req, v);
            bus_a(e.wr, adr_a(2, 1'b1, e.off), 4'd8);
            chk(a_rv == e.rv, {tag, " rsp_valid"}, {63'd0, a_rv}, {63'd0, e.rv});
            if (e.rv) chk(a_rd == {62'd0, e.rd}, {tag, " data"}, a_rd, {62'd0, e.rd});
            chk(!a_err, {tag, " err"}, {63'd0, a_err}, 64'd0);
            chk(a_nv == e.nv && (!e.nv || a_ns == 3'd2), {tag, " notify R12"},
                {60'd0, a_nv, a_ns}, {60'd0, e.nv, 3'd2});
        end

        // R7 trigger page on source 3
        bus_a(1'b1, adr_a(3, 1'b1, 12'hC00), 4'd8);
        bus_a(1'b1, adr_a(3, 1'b0, 12'hC00), 4'd8);
        chk(a_nv && a_ns == 3'd3, "R7 trigger page store triggers", {60'd0, a_nv, a_ns}, {60'd0, 1'b1, 3'd3});
        get_a(3, 2'b10, "R7 trigger page store not a set");
        bus_a(1'b0, adr_a(3, 1'b0, 12'h800), 4'd8);
        chk(a_rv && a_err && a_rd == '1, "R7 trigger page load", a_rd, '1);
        get_a(3, 2'b10, "R7 trigger page load no side effect");

        // R8 invalid accesses
        bus_a(1'b1, adr_a(3, 1'b1, 12'h800), 4'd8);
        chk(a_err, "R8 store at 0x800 flagged", {63'd0, a_err}, 64'd1);
        get_a(3, 2'b10, "R8 store at 0x800 ignored");
        bus_a(1'b0, adr_a(3, 1'b1, 12'hC00), 4'd4);
        chk(a_rv && a_err && a_rd == '1, "R8 short load", a_rd, '1);
        get_a(3, 2'b10, "R8 short load changed nothing");
        bus_a(1'b0, adr_a(9, 1'b1, 12'hC00), 4'd8);
        chk(a_rv && a_err && a_rd == '1, "R8 source out of range load", a_rd, '1);
        bus_a(1'b1, adr_a(9, 1'b1, 12'hC00), 4'd8);
        chk(a_err && !a_nv, "R8 source out of range store", {62'd0, a_err, a_nv}, 64'd2);
        get_a(1, 2'b01, "R8 no alias onto source 1");

        // R9 wired edge on source 5
        bus_a(1'b1, adr_a(5, 1'b1, 12'hC00), 4'd8);
        seen.delete();
        irq_a[5] = 1'b1;
        repeat (6) @(negedge clk);
        irq_a[5] = 1'b0;
        repeat (3) @(negedge clk);
        chk(seen.size() == 1 && seen[0] == 5, "R9 one notify per edge", 64'(seen.size()), 64'd1);
        get_a(5, 2'b10, "R9 held level triggers once");
        irq_a[5] = 1'b1;
        repeat (3) @(negedge clk);
        irq_a[5] = 1'b0;
        get_a(5, 2'b11, "R9 second edge coalesced");
        chk(seen.size() == 1, "R9 coalesced edge silent", 64'(seen.size()), 64'd1);

        // R10 same-cycle collisions
        bus_a(1'b1, adr_a(6, 1'b1, 12'hF00), 4'd8);
        irq_a[6] = 1'b1;
        bus_a(1'b1, adr_a(6, 1'b1, 12'h400), 4'd8);
        chk(a_nv && a_ns == 3'd6, "R10 eoi then trigger notify", {60'd0, a_nv, a_ns}, {60'd0, 1'b1, 3'd6});
        get_a(6, 2'b11, "R10 eoi then trigger state");
        irq_a[6] = 1'b0;
        bus_a(1'b1, adr_a(7, 1'b1, 12'hE00), 4'd8);
        irq_a[7] = 1'b1;
        bus_a(1'b1, adr_a(7, 1'b1, 12'hC00), 4'd8);
        chk(a_nv && a_ns == 3'd7, "R10 set then trigger notify", {60'd0, a_nv, a_ns}, {60'd0, 1'b1, 3'd7});
        get_a(7, 2'b10, "R10 set then trigger state");
        irq_a[7] = 1'b0;

        // R11 burst of edges plus a bus trigger
        for (int s = 0; s < 8; s++) bus_a(1'b1, adr_a(s, 1'b1, 12'hC00), 4'd8);
        repeat (2) @(negedge clk);
        seen.delete();
        irq_a = 8'hFF;
        bus_a(1'b1, adr_a(0, 1'b1, 12'h000), 4'd8);
        repeat (14) @(negedge clk);
        irq_a = 8'h00;
        chk(seen.size() == 8, "R11 no notify lost", 64'(seen.size()), 64'd8);
        for (int k = 0; k < 8; k++) begin
            int got;
            got = (k < seen.size()) ? seen[k] : -1;
            chk(got == k, "R11 notify order", 64'(got), 64'(k));
        end
        get_a(0, 2'b11, "R11 bus trigger before wired on source 0");

        // R6 and one-page layout on instance B, source 1
        bus_b(1'b1, 16'h1F00);
        bus_b(1'b1, 16'h1400);
        chk(b_err && !b_nv, "R6 store eoi disabled flagged", {62'd0, b_err, b_nv}, 64'd2);
        bus_b(1'b0, 16'h1800);
        chk(b_rv && b_rd == 64'd3, "R6 store eoi disabled ignored", b_rd, 64'd3);
        bus_b(1'b0, 16'h1000);
        chk(b_rv && b_rd == 64'd1 && b_nv && b_ns == 2'd1, "R3 one-page load eoi", b_rd, 64'd1);
        bus_b(1'b1, 16'h1C00);
        bus_b(1'b1, 16'h1000);
        chk(b_nv && b_ns == 2'd1, "R5 one-page store trigger", {61'd0, b_nv, b_ns}, {61'd0, 1'b1, 2'd1});

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule